// File: doc/BRIEF.md
# Serial Configuration Register Chain

This block is a three-wire serial configuration port that loads a 48-bit control word, arranged as six bytes, into a chip. While the active-low write enable is held low, each rising edge of the serial clock captures one bit from the serial data pin and moves the chain along by one place. Within each byte the most significant bit goes first, and byte 1 is the first byte sent. When the enable returns high, the whole chain is copied into a shadow register, and the shadow register drives the control outputs. The controls therefore change only at the moment the enable rises.

The last stage of the chain drives a monitor pin. This lets a host read back the word it loaded earlier by clocking in the next word. The shadow register is decoded into named controls:
- a 3-bit oscillator band select, together with a one-hot enable for six bands;
- two charge-pump current bits, one for the frequency loop and one for the phase loop;
- a bit that selects the clock-input buffer mode;
- five 8-bit trim values.

An asynchronous reset clears the chain and the shadow register, which leaves every oscillator off.

Top module: `sercfg_chain`

## Requirements
- R1: While `rst_n` is low, the chain and the shadow register are zero. As a result, `sdo`, every field output and `osc_en` read 0.
- R2: On a rising `scl` edge with `wen_n` low, the chain shifts by one place and takes `sdi` into its first stage. Bits are sent MSB first within a byte, and byte 1 is sent first, so after 48 clocks byte 1 sits at chain bits 47:40 and byte 6 at bits 7:0.
- R3: A rising `scl` edge with `wen_n` high leaves the chain unchanged. Changes on `sdi` at such edges change neither `sdo` nor any later readback.
- R4: The field outputs change only when `wen_n` rises, and they then take the chain contents. While bits are shifting, the outputs keep their previous values.
- R5: `sdo` is the last chain stage. During a load, after k shifts `sdo` shows bit 47-k of the previously held chain, so the earlier word comes back in the order it was sent.
- R6: Byte 1 is decoded as follows:
  - bits 7:5 form `osc_sel`;
  - bits 4:3 are unused;
  - bit 2 drives `pump_freq`;
  - bit 1 drives `clk_in_lvds` (0 selects CML, 1 selects LVDS);
  - bit 0 drives `pump_phase`.
- R7: Bytes 2 to 6 drive, in that order, `trim_delay`, `trim_inpeak`, `trim_range`, `trim_outpk2` and `trim_outpk1`.
- R8: `osc_en` is one-hot, with bit n-1 set for `osc_sel` code n (n = 1 to 6). For codes 0 and 7, all bits of `osc_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Serial clock; bits are captured on its rising edge |
| sdi | input | 1 | Serial data in |
| wen_n | input | 1 | Active-low write enable; its rising edge updates the outputs |
| sdo | output | 1 | Last stage of the chain, used for readback |
| osc_sel | output | 3 | Oscillator band select code |
| osc_en | output | 6 | One-hot band enable |
| pump_freq | output | 1 | Frequency-loop pump current bit |
| pump_phase | output | 1 | Phase-loop pump current bit |
| clk_in_lvds | output | 1 | Clock input buffer mode (1 = LVDS) |
| trim_delay | output | 8 | Clock-phase delay trim |
| trim_inpeak | output | 8 | Input peaking trim |
| trim_range | output | 8 | Oscillator range trim |
| trim_outpk2 | output | 8 | Second output peaking trim |
| trim_outpk1 | output | 8 | First output peaking trim |

## Verification
The assertions check three things on every serial clock edge:
- `osc_en` never has more than one bit set, and it is zero for the disabled codes;
- `sdo` holds while the enable is high;
- the shadow outputs hold while shifting continues.

Only the bench's scenarios can show the following:
- the byte and bit ordering of a full 48-bit load, and the mapping of every field;
- the in-order readback of an earlier word;
- that clocks with the enable high leave the held word intact.

Each of these needs a complete load sequence and expected values computed from the word that was sent.

// File: rtl/sercfg_chain.sv
module sercfg_chain #(
  parameter int NBYTES = 6,
  parameter int SELW   = 3
) (
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sdi,
  input  logic       wen_n,
  output logic       sdo,
  output logic [2:0] osc_sel,
  output logic [5:0] osc_en,
  output logic       pump_freq,
  output logic       pump_phase,
  output logic       clk_in_lvds,
  output logic [7:0] trim_delay,
  output logic [7:0] trim_inpeak,
  output logic [7:0] trim_range,
  output logic [7:0] trim_outpk2,
  output logic [7:0] trim_outpk1
);

  localparam int W      = NBYTES * 8;
  localparam int NBANDS = (1 << SELW) - 2;

  logic [W-1:0] chain_q;
  logic [W-1:0] shadow_q;

  always_ff @(posedge scl or negedge rst_n) begin
    if (!rst_n)      chain_q <= '0;
    else if (!wen_n) chain_q <= {chain_q[W-2:0], sdi};
  end

  always_ff @(posedge wen_n or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= chain_q;
  end

  assign sdo = chain_q[W-1];

  assign osc_sel     = shadow_q[W-1 -: SELW];
  assign pump_freq   = shadow_q[W-6];
  assign clk_in_lvds = shadow_q[W-7];
  assign pump_phase  = shadow_q[W-8];
  assign trim_delay  = shadow_q[W-9  -: 8];
  assign trim_inpeak = shadow_q[W-17 -: 8];
  assign trim_range  = shadow_q[W-25 -: 8];
  assign trim_outpk2 = shadow_q[W-33 -: 8];
  assign trim_outpk1 = shadow_q[W-41 -: 8];

  for (genvar b = 0; b < NBANDS; b++) begin : g_band
    assign osc_en[b] = (osc_sel == SELW'(b + 1));
  end

  // R8
  osc_onehot_chk: assert property (@(posedge scl) disable iff (!rst_n)
    $onehot0(osc_en));

  // R8
  osc_off_chk: assert property (@(posedge scl) disable iff (!rst_n)
    (osc_sel == '0 || osc_sel == '1) |-> (osc_en == '0));

  // R3
  sdo_hold_chk: assert property (@(posedge scl) disable iff (!rst_n)
    wen_n |=> $stable(sdo));

  // R4
  shadow_hold_chk: assert property (@(posedge scl) disable iff (!rst_n)
    (!wen_n && $past(!wen_n)) |-> ($stable(trim_delay) && $stable(osc_sel) && $stable(trim_outpk1)));

endmodule

// File: tb/sercfg_chain_tb.sv
module sercfg_chain_tb;
  localparam time CLK_PERIOD = 10ns;

  logic rst_n = 1'b0, scl = 1'b0, sdi = 1'b0, wen_n = 1'b1;
  logic sdo, pump_freq, pump_phase, clk_in_lvds;
  logic [2:0] osc_sel;
  logic [5:0] osc_en;
  logic [7:0] trim_delay, trim_inpeak, trim_range, trim_outpk2, trim_outpk1;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [47:0] exp_chain = '0, exp_shadow = '0;

  sercfg_chain u_dut (
    .rst_n(rst_n), .scl(scl), .sdi(sdi), .wen_n(wen_n), .sdo(sdo),
    .osc_sel(osc_sel), .osc_en(osc_en), .pump_freq(pump_freq),
    .pump_phase(pump_phase), .clk_in_lvds(clk_in_lvds),
    .trim_delay(trim_delay), .trim_inpeak(trim_inpeak), .trim_range(trim_range),
    .trim_outpk2(trim_outpk2), .trim_outpk1(trim_outpk1));

  always #(CLK_PERIOD/2) scl = ~scl;

  function automatic logic [5:0] band_of(input logic [2:0] code);
    if (code == 3'd0 || code == 3'd7) return 6'd0;
    return 6'd1 << (code - 1);
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_fields(input string req);
    chk({req, " R6"}, "osc_sel",     64'(osc_sel),     64'(exp_shadow[47:45]));
    chk({req, " R6"}, "pump_freq",   64'(pump_freq),   64'(exp_shadow[42]));
    chk({req, " R6"}, "clk_in_lvds", 64'(clk_in_lvds), 64'(exp_shadow[41]));
    chk({req, " R6"}, "pump_phase",  64'(pump_phase),  64'(exp_shadow[40]));
    chk({req, " R7"}, "trim_delay",  64'(trim_delay),  64'(exp_shadow[39:32]));
    chk({req, " R7"}, "trim_inpeak", 64'(trim_inpeak), 64'(exp_shadow[31:24]));
    chk({req, " R7"}, "trim_range",  64'(trim_range),  64'(exp_shadow[23:16]));
    chk({req, " R7"}, "trim_outpk2", 64'(trim_outpk2), 64'(exp_shadow[15:8]));
    chk({req, " R7"}, "trim_outpk1", 64'(trim_outpk1), 64'(exp_shadow[7:0]));
    chk({req, " R8"}, "osc_en",      64'(osc_en),      64'(band_of(exp_shadow[47:45])));
  endtask

  task automatic load(input logic [47:0] v);
    int bad = 0;
    logic [47:0] got = '0;
    @(negedge scl);
    wen_n = 1'b0;
    for (int i = 0; i < 48; i++) begin
      sdi = v[47-i];
      got[47-i] = sdo;
      if (i == 24) chk_fields("R4 mid-shift");
      @(negedge scl);
    end
    // R5: the old word streams out of sdo in sent order
    chk("R5", "readback", 64'(got), 64'(exp_chain));
    wen_n = 1'b1;
    #1;
    exp_chain  = v;
    exp_shadow = v;
    chk_fields("R2");
  endtask

  task automatic idle_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge scl);
      sdi = 1'($urandom);
    end
    #1;
    // R3: with the enable high, clocks leave sdo and outputs unchanged
    chk("R3", "sdo idle", 64'(sdo), 64'(exp_chain[47]));
    chk_fields("R3");
  endtask

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD*2);
    #1;
    // R1: reset state
    chk("R1", "sdo reset", 64'(sdo), 64'd0);
    chk_fields("R1");
    @(negedge scl);
    rst_n = 1'b1;

    load(48'h5A_C3_81_7E_FF_00);
    load(48'hA5_12_34_56_78_9A);
    for (int c = 0; c < 8; c++) load({3'(c), 5'b11011, 40'h0123456789 ^ 40'(c)});
    idle_clocks(30);
    load(48'h0);
    for (int k = 0; k < 20; k++) begin
      load({$urandom, 16'($urandom)});
      if (k % 5 == 2) idle_clocks(7);
    end
    load(48'hFF_FF_FF_FF_FF_FF);

    @(negedge scl);
    rst_n = 1'b0;
    #1;
    exp_chain  = '0;
    exp_shadow = '0;
    chk("R1", "sdo async reset", 64'(sdo), 64'd0);
    chk_fields("R1 async");
    @(negedge scl);
    rst_n = 1'b1;
    load(48'h21_00_00_00_00_01);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge scl);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule